// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for each beat of a short burst into a synchronous memory. A load cycle captures a complete external address and the read/write type of the access. Each following advance cycle steps the two low address bits to the next beat. The upper bits stay where the load put them. The stepping order is either a plain count or an XOR pattern against the starting offset, and a static order-select input picks which. After four beats the low bits wrap back to the starting offset and nothing carries into the upper bits.

A stall input freezes the whole sequencer. A load cycle with the chip select inactive makes the sequencer idle. Advance cycles after that keep it idle, because only a new load can begin an access. The byte-lane enables are not kept from the load cycle. They are registered on every accepted edge, so each beat of a burst write carries its own lane mask.

Top module: `burst_addr_seq`

## Requirements
- R1: Synchronous active-low reset clears `active`, `is_write`, `beat`, `byte_en_out` and `cur_addr` to zero.
- R2: On an accepted edge (`stall`=0) with `start`=1 and `chip_sel`=1, the next cycle shows `cur_addr`=`addr_in`, `beat`=0, `active`=1 and `is_write`=`wr_req`.
- R3: With `order_mode`=0 (linear), the low two bits of `cur_addr` equal (start offset + `beat`) mod 4, so each advance adds 1 modulo 4.
- R4: With `order_mode`=1 (interleaved), the low two bits of `cur_addr` equal start offset XOR `beat`. For example, start 2 gives 2,3,0,1 and start 3 gives 3,2,1,0.
- R5: An accepted edge with `start`=0 increments `beat` modulo 4. After four advances the low bits are back at the start offset, and the upper address bits never change on an advance.
- R6: On an advance edge, `chip_sel` and `wr_req` have no effect. `active` and `is_write` keep the values set by the last load.
- R7: A load edge with `chip_sel`=0 sets `active`=0, `is_write`=0 and `beat`=0 and leaves the address unchanged. Advances after that keep `active`=0.
- R8: While `stall`=1, all inputs are ignored, including `start` and `rst_n`=1 traffic. `cur_addr`, `beat`, `active`, `is_write` and `byte_en_out` hold their values.
- R9: `byte_en_out` is `byte_en_in` as sampled on the most recent accepted edge, on both load and advance edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | 1 = ignore this edge and hold all state |
| start | input | 1 | 1 = load a new address, 0 = advance the burst |
| chip_sel | input | 1 | Combined chip select, sampled only on load edges |
| wr_req | input | 1 | 1 = write access, sampled only on selected load edges |
| order_mode | input | 1 | Static burst order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External address captured on a selected load |
| byte_en_in | input | BYTES | Byte-lane enables, sampled on every accepted edge |
| cur_addr | output | ADDR_W | Address of the current beat |
| beat | output | BEAT_W | Beat count since the last load |
| active | output | 1 | An access is in progress (not deselected) |
| is_write | output | 1 | Type held from the load edge, 1 = write |
| byte_en_out | output | BYTES | Lane enables for the current beat |

## Verification
The bench runs advance chains longer than four beats from every kind of start offset. A design that carried into bit 2, or that added instead of XORing in interleaved mode, would show a wrong address on the wrapping or odd-start beat. Advances are driven with `chip_sel` low and `wr_req` inverted. This exposes a design that re-sampled them mid-burst: it would flip `is_write` or drop `active`. Stalls are placed on load edges and in the middle of bursts, where a leak would show as a moved address or a changed beat. Deselected loads followed by advances catch a sequencer that wakes up without a load.

// File: rtl/burst_seq_pkg.sv
// Shared definitions for the burst address sequencer.
// Assumes a four-beat burst by default; widths are set at the top.
package burst_seq_pkg;
    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;

    localparam int DEF_BEAT_W = 2;
endpackage

// File: rtl/burst_offset.sv
// Maps a start offset and beat count to the low address bits of a beat.
// Assumes the count wraps naturally at 2**BEAT_W; purely combinational.
module burst_offset #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_off,
    input  logic [BEAT_W-1:0] count,
    input  logic              mode,
    output logic [BEAT_W-1:0] offset
);
    import burst_seq_pkg::*;

    logic [BEAT_W-1:0] lin_off;
    logic [BEAT_W-1:0] ilv_off;

    // Compute both orders; the adder drops its carry so it wraps in the group.
    always_comb begin
        lin_off = start_off + count;
        ilv_off = start_off ^ count;
    end

    // Select the order named by the static mode input.
    always_comb begin
        if (order_e'(mode) == ORDER_INTERLEAVE)
            offset = ilv_off;
        else
            offset = lin_off;
    end
endmodule

// File: rtl/burst_state.sv
// Holds the burst base address, start offset, beat count and access type.
// Assumes stall=1 freezes every register; reset is synchronous, active low.
module burst_state #(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              start,
    input  logic              chip_sel,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_addr,
    output logic [BEAT_W-1:0] start_off,
    output logic [BEAT_W-1:0] count,
    output logic              active,
    output logic              is_write
);
    // Load, deselect or advance on each accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            start_off <= '0;
            count     <= '0;
            active    <= 1'b0;
            is_write  <= 1'b0;
        end else if (!stall) begin
            if (start) begin
                count <= '0;
                if (chip_sel) begin
                    base_addr <= addr_in;
                    start_off <= addr_in[BEAT_W-1:0];
                    active    <= 1'b1;
                    is_write  <= wr_req;
                end else begin
                    active    <= 1'b0;
                    is_write  <= 1'b0;
                end
            end else begin
                count <= count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lane_latch.sv
// Registers the byte-lane enables on every accepted edge, one flop per lane.
// Assumes lanes are independent; no lane mask is kept from the load edge.
module lane_latch #(
    parameter int BYTES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic [BYTES-1:0] lane_in,
    output logic [BYTES-1:0] lane_out
);
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        // Capture this lane's enable unless the edge is stalled.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_out[g] <= 1'b0;
            else if (!stall)
                lane_out[g] <= lane_in[g];
        end
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Top of the burst address sequencer: loads an address, then steps its low
// bits in linear or interleaved order while holding the upper bits and type.
// Assumes order_mode is static while a burst runs.
module burst_addr_seq #(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = burst_seq_pkg::DEF_BEAT_W,
    parameter int BYTES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              start,
    input  logic              chip_sel,
    input  logic              wr_req,
    input  logic              order_mode,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BYTES-1:0]  byte_en_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [BEAT_W-1:0] beat,
    output logic              active,
    output logic              is_write,
    output logic [BYTES-1:0]  byte_en_out
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base_addr;
    logic [BEAT_W-1:0] start_off;
    logic [BEAT_W-1:0] beat_off;

    burst_state #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall),
        .start     (start),
        .chip_sel  (chip_sel),
        .wr_req    (wr_req),
        .addr_in   (addr_in),
        .base_addr (base_addr),
        .start_off (start_off),
        .count     (beat),
        .active    (active),
        .is_write  (is_write)
    );

    burst_offset #(.BEAT_W(BEAT_W)) u_offset (
        .start_off (start_off),
        .count     (beat),
        .mode      (order_mode),
        .offset    (beat_off)
    );

    lane_latch #(.BYTES(BYTES)) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (stall),
        .lane_in  (byte_en_in),
        .lane_out (byte_en_out)
    );

    // Join the fixed upper bits with the stepped low bits.
    always_comb begin
        cur_addr = {base_addr[ADDR_W-1:BEAT_W], beat_off};
    end

    logic [UPPER_W-1:0] unused_upper;
    assign unused_upper = base_addr[ADDR_W-1:BEAT_W];
endmodule

// File: rtl/burst_addr_seq_chk.sv
// Protocol checker for burst_addr_seq, attached by bind below.
// Assumes order_mode is held constant around the edges it checks.
module burst_addr_seq_chk #(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2,
    parameter int BYTES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              start,
    input logic              chip_sel,
    input logic              wr_req,
    input logic              order_mode,
    input logic [ADDR_W-1:0] addr_in,
    input logic [BYTES-1:0]  byte_en_in,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [BEAT_W-1:0] beat,
    input logic              active,
    input logic              is_write,
    input logic [BYTES-1:0]  byte_en_out
);
    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && start && chip_sel) |=>
            (active && cur_addr == $past(addr_in) && beat == '0 && is_write == $past(wr_req)));

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !start && !order_mode) |=>
            (order_mode || cur_addr[BEAT_W-1:0] == BEAT_W'($past(cur_addr[BEAT_W-1:0]) + 1'b1)));

    // R5
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !start) |=> (cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W])));

    // R6
    type_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !start) |=> (is_write == $past(is_write) && active == $past(active)));

    // R7
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && start && !chip_sel) |=> (!active && !is_write && beat == '0));

    // R8
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(beat) && $stable(active) && $stable(is_write) && $stable(byte_en_out)));

    // R9
    lane_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (byte_en_out == $past(byte_en_in)));

    logic unused_ok;
    assign unused_ok = ^addr_in;
endmodule

bind burst_addr_seq burst_addr_seq_chk #(
    .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .BYTES(BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .stall(stall), .start(start),
    .chip_sel(chip_sel), .wr_req(wr_req), .order_mode(order_mode),
    .addr_in(addr_in), .byte_en_in(byte_en_in), .cur_addr(cur_addr),
    .beat(beat), .active(active), .is_write(is_write),
    .byte_en_out(byte_en_out)
);

// File: tb/burst_addr_seq_test.sv
// Bench for burst_addr_seq: a behavioural model updated per edge and
// compared with every output one time unit after each rising edge.
module burst_addr_seq_test;
    localparam int AW = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stall = 1'b0, start = 1'b0, chip_sel = 1'b0, wr_req = 1'b0, order_mode = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [1:0] byte_en_in = '0;
    logic [AW-1:0] cur_addr;
    logic [1:0] beat;
    logic active, is_write;
    logic [1:0] byte_en_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int m_base = 0, m_start = 0, m_cnt = 0, m_be = 0;
    bit m_act = 0, m_wr = 0;

    always #5 clk = ~clk;

    burst_addr_seq uut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .start(start),
        .chip_sel(chip_sel), .wr_req(wr_req), .order_mode(order_mode),
        .addr_in(addr_in), .byte_en_in(byte_en_in), .cur_addr(cur_addr),
        .beat(beat), .active(active), .is_write(is_write),
        .byte_en_out(byte_en_out)
    );

    task automatic compare(input string tag);
        int low, exp_addr;
        if (order_mode) low = m_start ^ m_cnt;
        else            low = (m_start + m_cnt) % 4;
        exp_addr = (m_base & 'h3FFFC) | low;
        checks++;
        if (int'(cur_addr) != exp_addr || int'(beat) != m_cnt || active != m_act ||
            is_write != m_wr || int'(byte_en_out) != m_be) begin
            errors++;
            $display("FAIL %s: addr=%h beat=%0d act=%0b wr=%0b be=%0d expected addr=%h beat=%0d act=%0b wr=%0b be=%0d",
                     tag, cur_addr, beat, active, is_write, byte_en_out,
                     exp_addr, m_cnt, m_act, m_wr, m_be);
        end
    endtask

    task automatic step(input string tag, input bit st_l, input bit s, input bit cs,
                        input bit wr, input int a, input int be);
        @(negedge clk);
        rst_n = 1'b1; stall = st_l; start = s; chip_sel = cs; wr_req = wr;
        addr_in = AW'(a); byte_en_in = 2'(be);
        @(posedge clk);
        #1;
        if (!st_l) begin
            m_be = be;
            if (s) begin
                m_cnt = 0;
                if (cs) begin
                    m_act = 1; m_wr = wr; m_base = a & 'h3FFFF; m_start = a & 3;
                end else begin
                    m_act = 0; m_wr = 0;
                end
            end else begin
                m_cnt = (m_cnt + 1) % 4;
            end
        end
        compare(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; stall = 1'b0; start = 1'b1; chip_sel = 1'b1; wr_req = 1'b1;
        addr_in = AW'('h3FFFF); byte_en_in = 2'b11;
        @(posedge clk);
        #1;
        m_base = 0; m_start = 0; m_cnt = 0; m_be = 0; m_act = 0; m_wr = 0;
        compare("R1 reset");
    endtask

    initial begin
        do_reset();
        do_reset();

        // R2 R3 R5 R6: linear read burst from offset 1, advances with noisy selects
        order_mode = 1'b0;
        step("R2 load read", 0, 1, 1, 0, 'h2ABC5, 1);
        for (int i = 0; i < 6; i++)
            step("R3 R5 R6 linear advance", 0, 0, i % 2, 1, 'h00000 + i, i % 4);

        // R9 R6: linear write burst from offset 3, fresh lane masks per beat
        step("R2 load write", 0, 1, 1, 1, 'h13F0F, 2);
        for (int i = 0; i < 5; i++)
            step("R9 R6 write beats", 0, 0, 0, 0, 'h3FFFF, (i + 1) % 4);

        // R8: stall in the middle of a burst and on a load edge
        step("R8 stall mid", 1, 0, 1, 0, 'h00000, 3);
        step("R8 stall load", 1, 1, 1, 0, 'h11111, 0);
        step("R3 resume", 0, 0, 1, 0, 'h11111, 1);

        // R7: deselect, then advances must stay idle
        step("R7 deselect", 0, 1, 0, 1, 'h22222, 2);
        for (int i = 0; i < 3; i++)
            step("R7 idle advance", 0, 0, 1, 1, 'h33333, i);

        // R4: interleaved from offsets 2 and 3 and 1
        @(negedge clk);
        order_mode = 1'b1;
        step("R2 load ilv", 0, 1, 1, 0, 'h0F0F2, 3);
        for (int i = 0; i < 5; i++)
            step("R4 R5 ilv start2", 0, 0, 0, 1, 'h0, 1);
        step("R2 load ilv3", 0, 1, 1, 1, 'h3C003, 0);
        for (int i = 0; i < 4; i++)
            step("R4 ilv start3", 0, 0, 1, 0, 'h0, 2);
        step("R8 stall ilv", 1, 0, 0, 0, 'h0, 3);
        step("R2 load ilv1", 0, 1, 1, 0, 'h00001, 1);
        for (int i = 0; i < 5; i++)
            step("R4 ilv start1", 0, 0, 0, 0, 'h0, 2);

        // R1: reset in the middle of a burst
        do_reset();
        step("R7 advance after reset", 0, 0, 1, 1, 'h12345, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule